// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Symbol Receiver

This block listens to a single-wire bus that carries information in the duration of its active and passive intervals. After a two-flop synchronizer it measures every interval in base ticks, counting only on cycles where `tick_en` is high. When an interval ends it is sorted into a data bit or a start-of-frame. Long passive and active intervals are recognised while they are still running.

Data bits are shifted into a byte, most significant bit first, and each full byte is presented with a one-cycle strobe. Framing conditions appear as one-cycle event pulses: start of frame, end of data, end of frame, inter-frame separator and break. Two error pulses are also provided. One reports a data bit that arrives outside a frame. The other reports a byte left incomplete at end of data.

Top module: `vpw_rx`

## Requirements
- R1: `bus_in` passes through two synchronizer flops. Interval lengths count only cycles with `tick_en` high, so the same symbol stream decodes identically when ticks arrive every second clock.
- R2: A passive (`bus_in`=0) interval of 32–95 ticks ending in an edge yields data bit 0. One of 96–163 ticks yields data bit 1.
- R3: An active (`bus_in`=1) interval of 32–95 ticks ending in an edge yields data bit 1. One of 96–163 ticks yields data bit 0.
- R4: An active interval of 164–239 ticks pulses `ev_sof` when it ends. It clears the bit count of the byte assembler and opens a frame.
- R5: Data bits inside a frame shift in MSB first. After every eighth bit, `rx_byte_valid` pulses for one cycle with the byte on `rx_byte`.
- R6: A passive interval that follows a valid active interval pulses `ev_eod` as its count reaches 164. If a partial byte is pending at that point, `ev_frame_err` pulses on the next cycle and the partial byte is discarded.
- R7: In that same passive interval, `ev_eof` pulses as the count reaches 240 and closes the frame. `ev_ifs` then pulses as the count reaches 281, so the order is end-of-data, then end-of-frame, then separator, each at most once. A passive interval that follows no valid active interval raises none of the three, including the idle period after reset.
- R8: An active interval pulses `ev_break` as its count reaches 240, while the bus is still active. The frame closes and the pending bits are dropped.
- R9: An interval shorter than 32 ticks produces no bit and no event.
- R10: A data bit decoded while no frame is open pulses `ev_invalid` and is not assembled.
- R11: During reset all outputs are 0.
- R12: At most one of `ev_sof`, `ev_eod`, `ev_eof`, `ev_ifs`, `ev_break` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Base tick enable for interval counting |
| bus_in | input | 1 | Asynchronous bus level, 1 = active |
| rx_byte | output | 8 | Last assembled byte |
| rx_byte_valid | output | 1 | One-cycle strobe for `rx_byte` |
| ev_sof | output | 1 | Start-of-frame pulse |
| ev_eod | output | 1 | End-of-data pulse |
| ev_eof | output | 1 | End-of-frame pulse |
| ev_ifs | output | 1 | Inter-frame separator pulse |
| ev_break | output | 1 | Break pulse |
| ev_invalid | output | 1 | Data bit outside a frame |
| ev_frame_err | output | 1 | Partial byte at end of data |

## Verification
An edge on `bus_in` reaches the edge detector two clocks later. The start-of-frame pulse and the decoded bit are registered one clock after that. The byte strobe and the invalid and frame-error pulses are registered one clock later still. Threshold crossings inside a running interval show one clock after the counter step. The bench never samples at those exact cycles. A negative-edge monitor counts every pulse and stores every byte, and the checks compare the tallies only after the stimulus has been idle for at least ten clocks. All stimulus widths stay at least four ticks away from any window edge, which absorbs the one-tick sampling uncertainty.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  typedef enum logic [1:0] {SYM_NONE, SYM_BIT0, SYM_BIT1, SYM_SOF} sym_e;

  // Sort a finished interval by level and length.
  function automatic sym_e classify(input logic active, input int unsigned len,
                                    input int unsigned noise_min, input int unsigned bit_split,
                                    input int unsigned sym_min, input int unsigned long_min);
    if (len < noise_min)       return SYM_NONE;
    else if (len < bit_split)  return active ? SYM_BIT1 : SYM_BIT0;
    else if (len < sym_min)    return active ? SYM_BIT0 : SYM_BIT1;
    else if (active && len < long_min) return SYM_SOF;
    else                       return SYM_NONE;
  endfunction

  // True on the counter step that brings the count to th.
  function automatic logic crossing(input logic step, input int unsigned cnt, input int unsigned th);
    return step && (cnt + 1 == th);
  endfunction
endpackage

// File: rtl/vpw_sync.sv
module vpw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vpw_interval_timer.sv
module vpw_interval_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             lvl_in,
  output logic             lvl_q,
  output logic             seg_end,
  output logic             seg_lvl,
  output logic [CNT_W-1:0] seg_len,
  output logic             tick_step
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  assign seg_end   = (lvl_in != lvl_q);
  assign seg_lvl   = lvl_q;
  assign seg_len   = cnt;
  assign tick_step = tick_en && !seg_end && (cnt != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_q <= lvl_in;
      if (seg_end)        cnt <= '0;
      else if (tick_step) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vpw_symbol_decode.sv
module vpw_symbol_decode
  import vpw_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned NOISE_MIN = 32,
  parameter int unsigned BIT_SPLIT = 96,
  parameter int unsigned SYM_MIN   = 164,
  parameter int unsigned LONG_MIN  = 240,
  parameter int unsigned IFS_MIN   = 281
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_end,
  input  logic             seg_lvl,
  input  logic [CNT_W-1:0] seg_len,
  input  logic             tick_step,
  output logic             ev_sof,
  output logic             ev_eod,
  output logic             ev_eof,
  output logic             ev_ifs,
  output logic             ev_break,
  output logic             bit_vld,
  output logic             bit_val
);
  sym_e sym;
  logic armed, x_eod, x_eof, x_ifs, x_brk, valid_active_end;

  always_comb begin
    sym = seg_end ? classify(seg_lvl, 32'(seg_len), NOISE_MIN, BIT_SPLIT, SYM_MIN, LONG_MIN)
                  : SYM_NONE;
  end

  assign valid_active_end = seg_end && seg_lvl && (32'(seg_len) >= NOISE_MIN);
  assign x_eod = armed && !seg_lvl && crossing(tick_step, 32'(seg_len), SYM_MIN);
  assign x_eof = armed && !seg_lvl && crossing(tick_step, 32'(seg_len), LONG_MIN);
  assign x_ifs = armed && !seg_lvl && crossing(tick_step, 32'(seg_len), IFS_MIN);
  assign x_brk = seg_lvl && crossing(tick_step, 32'(seg_len), LONG_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      ev_sof   <= 1'b0;
      ev_eod   <= 1'b0;
      ev_eof   <= 1'b0;
      ev_ifs   <= 1'b0;
      ev_break <= 1'b0;
      bit_vld  <= 1'b0;
      bit_val  <= 1'b0;
    end else begin
      if (valid_active_end) armed <= 1'b1;
      else if (x_ifs)       armed <= 1'b0;
      ev_sof   <= (sym == SYM_SOF);
      ev_eod   <= x_eod;
      ev_eof   <= x_eof;
      ev_ifs   <= x_ifs;
      ev_break <= x_brk;
      bit_vld  <= (sym == SYM_BIT0) || (sym == SYM_BIT1);
      bit_val  <= (sym == SYM_BIT1);
    end
  end
endmodule

// File: rtl/vpw_byte_asm.sv
module vpw_byte_asm #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              eod,
  input  logic              eof,
  input  logic              brk,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_byte_valid,
  output logic              ev_invalid,
  output logic              ev_frame_err,
  output logic              in_frame
);
  localparam int unsigned BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [BC_W-1:0]   nbits;
  logic [DATA_W-1:0] shifted;

  assign shifted = {shreg[DATA_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg         <= '0;
      nbits         <= '0;
      rx_byte       <= '0;
      rx_byte_valid <= 1'b0;
      ev_invalid    <= 1'b0;
      ev_frame_err  <= 1'b0;
      in_frame      <= 1'b0;
    end else begin
      rx_byte_valid <= 1'b0;
      ev_invalid    <= 1'b0;
      ev_frame_err  <= 1'b0;
      if (sof) begin
        in_frame <= 1'b1;
        nbits    <= '0;
      end else if (brk) begin
        in_frame <= 1'b0;
        nbits    <= '0;
      end else if (eod) begin
        ev_frame_err <= (nbits != '0);
        nbits        <= '0;
      end else if (eof) begin
        in_frame <= 1'b0;
      end else if (bit_vld) begin
        if (!in_frame) begin
          ev_invalid <= 1'b1;
        end else begin
          shreg <= shifted;
          if (nbits == LAST) begin
            rx_byte       <= shifted;
            rx_byte_valid <= 1'b1;
            nbits         <= '0;
          end else begin
            nbits <= nbits + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vpw_rx.sv
module vpw_rx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NOISE_MIN = 32,
  parameter int unsigned BIT_SPLIT = 96,
  parameter int unsigned SYM_MIN   = 164,
  parameter int unsigned LONG_MIN  = 240,
  parameter int unsigned IFS_MIN   = 281
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_in,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_byte_valid,
  output logic              ev_sof,
  output logic              ev_eod,
  output logic              ev_eof,
  output logic              ev_ifs,
  output logic              ev_break,
  output logic              ev_invalid,
  output logic              ev_frame_err
);
  localparam int unsigned CNT_W = $clog2(IFS_MIN + 1) + 1;

  logic             lvl_in, lvl_q, seg_end, seg_lvl, tick_step;
  logic [CNT_W-1:0] seg_len;
  logic             bit_vld, bit_val, in_frame;

  vpw_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(lvl_in)
  );

  vpw_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .lvl_in(lvl_in), .lvl_q(lvl_q),
    .seg_end(seg_end), .seg_lvl(seg_lvl), .seg_len(seg_len), .tick_step(tick_step)
  );

  vpw_symbol_decode #(
    .CNT_W(CNT_W), .NOISE_MIN(NOISE_MIN), .BIT_SPLIT(BIT_SPLIT),
    .SYM_MIN(SYM_MIN), .LONG_MIN(LONG_MIN), .IFS_MIN(IFS_MIN)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .seg_end(seg_end), .seg_lvl(seg_lvl), .seg_len(seg_len),
    .tick_step(tick_step), .ev_sof(ev_sof), .ev_eod(ev_eod), .ev_eof(ev_eof),
    .ev_ifs(ev_ifs), .ev_break(ev_break), .bit_vld(bit_vld), .bit_val(bit_val)
  );

  vpw_byte_asm #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .sof(ev_sof), .eod(ev_eod), .eof(ev_eof), .brk(ev_break),
    .bit_vld(bit_vld), .bit_val(bit_val), .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid),
    .ev_invalid(ev_invalid), .ev_frame_err(ev_frame_err), .in_frame(in_frame)
  );
endmodule

// File: rtl/vpw_rx_chk.sv
module vpw_rx_chk #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned NOISE_MIN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_sof,
  input logic             ev_eod,
  input logic             ev_eof,
  input logic             ev_ifs,
  input logic             ev_break,
  input logic             ev_invalid,
  input logic             rx_byte_valid,
  input logic             bus_lvl,
  input logic             seg_end,
  input logic [CNT_W-1:0] seg_len,
  input logic             bit_vld,
  input logic             in_frame
);
  p_events_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_sof, ev_eod, ev_eof, ev_ifs, ev_break}));

  p_eof_while_passive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eof || ev_ifs) |-> !bus_lvl);

  p_break_while_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |-> bus_lvl);

  p_noise_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && (32'(seg_len) < NOISE_MIN)) |=> (!bit_vld && !ev_sof));

  p_sof_opens_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> (in_frame && !rx_byte_valid));

  p_byte_inside_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |-> $past(in_frame));

  p_invalid_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_invalid |-> !in_frame);
endmodule

bind vpw_rx vpw_rx_chk #(.CNT_W(CNT_W), .NOISE_MIN(NOISE_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_eod(ev_eod), .ev_eof(ev_eof),
  .ev_ifs(ev_ifs), .ev_break(ev_break), .ev_invalid(ev_invalid),
  .rx_byte_valid(rx_byte_valid), .bus_lvl(lvl_q), .seg_end(seg_end),
  .seg_len(seg_len), .bit_vld(bit_vld), .in_frame(in_frame)
);

// File: tb/tb_vpw_rx.sv
module tb_vpw_rx;
  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_in = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_byte_valid, ev_sof, ev_eod, ev_eof, ev_ifs, ev_break, ev_invalid, ev_frame_err;

  vpw_rx dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_in(bus_in), .rx_byte(rx_byte),
    .rx_byte_valid(rx_byte_valid), .ev_sof(ev_sof), .ev_eod(ev_eod), .ev_eof(ev_eof),
    .ev_ifs(ev_ifs), .ev_break(ev_break), .ev_invalid(ev_invalid), .ev_frame_err(ev_frame_err)
  );

  always #2 clk = ~clk;

  int tdiv = 1, tph = 0;
  always @(negedge clk) begin
    if (tph + 1 >= tdiv) begin tick_en <= 1'b1; tph <= 0; end
    else begin tick_en <= 1'b0; tph <= tph + 1; end
  end

  int nchk = 0, nerr = 0, cyc = 0;
  int c_sof, c_eod, c_eof, c_ifs, c_brk, c_inv, c_ferr, nb;
  int t_eod, t_eof, t_ifs;
  logic [7:0] got [0:63];
  logic [7:0] expb [0:63];
  int ne;
  bit done = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (ev_sof) c_sof <= c_sof + 1;
      if (ev_eod) begin c_eod <= c_eod + 1; t_eod <= cyc; end
      if (ev_eof) begin c_eof <= c_eof + 1; t_eof <= cyc; end
      if (ev_ifs) begin c_ifs <= c_ifs + 1; t_ifs <= cyc; end
      if (ev_break) c_brk <= c_brk + 1;
      if (ev_invalid) c_inv <= c_inv + 1;
      if (ev_frame_err) c_ferr <= c_ferr + 1;
      if (rx_byte_valid) begin
        if (nb < 64) got[nb] <= rx_byte;
        nb <= nb + 1;
      end
    end
  end

  task automatic clear();
    @(negedge clk); #1;
    c_sof = 0; c_eod = 0; c_eof = 0; c_ifs = 0; c_brk = 0; c_inv = 0; c_ferr = 0;
    nb = 0; ne = 0; t_eod = 0; t_eof = 0; t_ifs = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Nominal and randomised widths, kept clear of every window edge.
  function automatic int width(input logic lvl, input logic b, input bit rnd);
    logic short_w;
    short_w = lvl ? b : !b;
    if (rnd) return short_w ? 36 + int'($urandom % 56) : 100 + int'($urandom % 60);
    return short_w ? 64 : 128;
  endfunction

  task automatic hold(input logic lvl, input int n);
    bus_in = lvl;
    repeat (n * tdiv) @(negedge clk);
  endtask

  task automatic send_sof(input bit rnd);
    hold(1'b1, rnd ? 168 + int'($urandom % 68) : 200);
  endtask

  task automatic send_byte(input logic [7:0] v, inout logic lvl, input bit rnd);
    for (int i = 7; i >= 0; i--) begin
      hold(lvl, width(lvl, v[i], rnd));
      lvl = ~lvl;
    end
    expb[ne] = v; ne++;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic check_bytes(input string tag);
    chk({tag, " byte count"}, nb, ne);
    for (int i = 0; i < ne && i < nb; i++) chk({tag, " byte value"}, int'(got[i]), int'(expb[i]));
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic lvl;
    void'($urandom(32'h1D5E_0C41));
    clear();
    repeat (5) @(negedge clk);
    // R11: all outputs low in reset
    chk("R11 outputs in reset", int'({rx_byte, rx_byte_valid, ev_sof, ev_eod, ev_eof, ev_ifs,
                                      ev_break, ev_invalid, ev_frame_err}), 0);
    rst_n = 1'b1;
    hold(1'b0, 330); settle();
    chk("R7 no framing events after reset idle", c_eod + c_eof + c_ifs, 0);

    // Directed frame: R2 R3 R4 R5 R6 R7
    clear(); lvl = 1'b0;
    send_sof(0); send_byte(8'hA5, lvl, 0); send_byte(8'h3C, lvl, 0);
    hold(1'b0, 330); settle();
    check_bytes("R5 R2 R3 directed");
    chk("R4 sof count", c_sof, 1);
    chk("R6 eod count", c_eod, 1);
    chk("R6 no frame error on full bytes", c_ferr, 0);
    chk("R7 eof count", c_eof, 1);
    chk("R7 ifs count", c_ifs, 1);
    chk("R7 eod before eof", int'(t_eod < t_eof), 1);
    chk("R7 eof before ifs", int'(t_eof < t_ifs), 1);
    chk("R10 no invalid in frame", c_inv, 0);

    // Random frames: R2 R3 R5 R7
    clear();
    for (int f = 0; f < 6; f++) begin
      int n;
      n = 1 + int'($urandom % 3);
      lvl = 1'b0;
      send_sof(1);
      for (int k = 0; k < n; k++) send_byte(8'($urandom), lvl, 1);
      hold(1'b0, 330);
    end
    settle();
    check_bytes("R5 R2 R3 random");
    chk("R4 random sof count", c_sof, 6);
    chk("R7 random eof count", c_eof, 6);
    chk("R7 random ifs count", c_ifs, 6);

    // Partial byte at end of data: R6
    clear(); lvl = 1'b0;
    send_sof(0); send_byte(8'h81, lvl, 0);
    for (int i = 0; i < 4; i++) begin hold(lvl, width(lvl, i[0], 0)); lvl = ~lvl; end
    hold(1'b0, 330); settle();
    check_bytes("R6 partial");
    chk("R6 frame error on leftover bits", c_ferr, 1);

    // Break during a frame: R8
    clear();
    send_sof(0); hold(1'b0, 64); hold(1'b1, 300); hold(1'b0, 330); settle();
    chk("R8 break count", c_brk, 1);
    chk("R8 no byte after break", nb, 0);
    chk("R8 pending bits dropped", c_ferr, 0);

    // Bit outside a frame: R10
    clear();
    hold(1'b1, 64); hold(1'b0, 330); settle();
    chk("R10 invalid count", c_inv, 1);
    chk("R10 no byte", nb, 0);

    // Noise pulse in idle: R9
    clear();
    hold(1'b1, 10); hold(1'b0, 40);
    chk("R9 no event after short pulse", c_sof + c_inv + c_brk + nb, 0);
    hold(1'b0, 330); settle();
    chk("R9 R7 no framing after noise", c_eod + c_eof + c_ifs, 0);

    // Half-rate ticks: R1
    clear(); tdiv = 2; lvl = 1'b0;
    send_sof(0); send_byte(8'h5A, lvl, 0); hold(1'b0, 330); settle();
    check_bytes("R1 half rate");
    chk("R1 half rate sof", c_sof, 1);
    tdiv = 1;

    // End of data without end of frame, then a new frame: R6 R7 R4
    clear(); lvl = 1'b0;
    send_sof(0); send_byte(8'h42, lvl, 0); hold(1'b0, 200);
    settle();
    chk("R6 eod on 200-tick passive", c_eod, 1);
    chk("R7 no eof below 240", c_eof, 0);
    lvl = 1'b0;
    send_sof(0); send_byte(8'hC3, lvl, 0); hold(1'b0, 330); settle();
    check_bytes("R4 second frame");
    chk("R4 two sof", c_sof, 2);
    chk("R7 one eof", c_eof, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule